// File: doc/BRIEF.md
# Lane High-Speed Entry and Exit Sequencer

This block drives the line states of one clock lane and one data lane of a serial display link. It moves each lane from the low-power stop state into high-speed transmission and back again. Every phase of both sequences lasts for a number of byte-clock cycles taken from 8-bit (or 4-bit) fields packed into four 32-bit timing words. The clock lane and the data lane use separate timing fields.

A burst request starts a data burst. The data lane cannot leave the stop state until the clock lane is running in high-speed mode. After the entry phases the data lane emits a sync byte and then the payload bytes that the upstream source offers with valid and last flags. It then holds a trail pattern and returns to stop. The clock lane either runs continuously while it is enabled, or in non-continuous mode starts only for a pending burst and stops after each one, once a guard time has passed.

Top module: `lane_hs_seq`

## Requirements
- R1: After reset both lanes show stop (line code 2'b11), both high-speed enables are low, `tx_ready` is low and `dat_byte` is 0x00.
- R2: Clock-lane entry shows LP-01 (2'b01) for the LPX field (word0[7:0]) cycles, then LP-00 (2'b00) for the clock-prepare field (word3[7:0]) cycles, then high speed for the clock-zero field (word2[19:16]) cycles plus one running cycle before the data lane shows LP-01.
- R3: The data lane leaves stop only when the clock lane is running. While `clk_hs_en` is low, `burst_req` has no effect on either lane.
- R4: Data-lane entry shows LP-01 for word0[7:0] cycles, then LP-00 for the prepare field (word0[15:8]) cycles, then high-speed bytes 0x00 for the zero field (word0[23:16]) cycles, then exactly one byte equal to SYNC_BYTE (0xB8).
- R5: `tx_ready` is high from the sync-byte cycle until a byte with `tx_last` is taken. A byte taken at a clock edge is on `dat_byte` in the cycle after that edge. `tx_ready` is high in exactly one cycle per payload byte.
- R6: After the last payload byte, `dat_byte` carries the inverse of bit 7 of that byte in all 8 bits, with `dat_hs_oe` high, for the trail field (word0[31:24]) cycles.
- R7: When `burst_req` is held high, the data lane shows stop for exactly the exit field (word1[31:24]) plus one cycles between the last trail byte and the next LP-01.
- R8: A timing field of value zero makes its phase last one cycle.
- R9: With `clk_noncont` high, the clock lane stays high-speed after the data lane leaves high speed until the data lane is idle and at least the clock-post field (word3[15:8]) cycles have passed. It then holds the clock-trail field (word2[31:24]) high-speed cycles and returns to stop. Total high-speed samples after the data drop are max(exit, post) + 1 + trail.
- R10: With `clk_noncont` low and `clk_hs_en` high, the clock lane starts without a burst request and keeps running after bursts. Dropping `clk_hs_en` gives the clock-trail field cycles of high speed, then stop.
- R11: After the clock lane leaves high speed, it shows stop for the clock-exit field (word3[19:16]) plus one cycles before a new LP-01 when a start is pending.
- R12: `dat_hs_oe` is never high while `clk_hs_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| t_word0 | input | 32 | Data timing: LPX, prepare, zero, trail |
| t_word1 | input | 32 | Data exit in [31:24]; turnaround fields stored by software only |
| t_word2 | input | 32 | Clock zero [19:16], clock trail [31:24] |
| t_word3 | input | 32 | Clock prepare [7:0], clock post [15:8], clock exit [19:16] |
| clk_hs_en | input | 1 | Clock lane high-speed enable |
| clk_noncont | input | 1 | Non-continuous clock select |
| burst_req | input | 1 | Level request for a data burst |
| tx_data | input | 8 | Payload byte |
| tx_valid | input | 1 | Payload byte valid |
| tx_last | input | 1 | Payload byte is the last of the burst |
| clk_lp | output | 2 | Clock lane low-power line code {P,N} |
| clk_hs_oe | output | 1 | Clock lane high-speed enable |
| dat_lp | output | 2 | Data lane low-power line code {P,N} |
| dat_hs_oe | output | 1 | Data lane high-speed enable |
| dat_byte | output | 8 | Byte for the serializer |
| tx_ready | output | 1 | Payload byte will be taken at the next edge |

## Verification
All outputs are registered from the next state, so every line state appears in the cycle after the edge that decides it. A phase of length N is therefore seen in exactly N consecutive samples. A byte offered while `tx_ready` is high shows on `dat_byte` one cycle later. The data lane reaches LP-01 one cycle after the clock lane starts running. The bench samples every output at the falling edge and drives inputs there. It counts run lengths of each line code and collects the high-speed byte stream. It then compares those counts with the field values, the zero-means-one rule and the max(exit, post) + 1 + trail formula for the clock tail.

// File: rtl/lhs_pkg.sv
package lhs_pkg;

  typedef enum logic [2:0] {
    CL_STOP, CL_REQ, CL_PREP, CL_ZERO, CL_RUN, CL_TRAIL, CL_EXIT
  } clk_st_e;

  typedef enum logic [3:0] {
    DL_IDLE, DL_REQ, DL_PREP, DL_ZERO, DL_SYNC, DL_PAY, DL_LAST,
    DL_TRAIL, DL_EXIT
  } dat_st_e;

  // line codes {P,N}
  localparam logic [1:0] LP_STOP = 2'b11;
  localparam logic [1:0] LP_HSRQ = 2'b01;
  localparam logic [1:0] LP_BRDG = 2'b00;

endpackage

// File: rtl/lhs_post_guard.sv
module lhs_post_guard #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dat_hs,
  input  logic [FW-1:0] post_len,
  output logic          ok_o
);

  logic [FW-1:0] cnt_q;
  logic [FW-1:0] need;

  // zero field counts as one cycle
  assign need = (post_len == '0) ? FW'(1) : post_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (dat_hs) begin
      cnt_q <= '0;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ok_o = (cnt_q >= need);

  a_r9_post_restarts: assert property (@(posedge clk) disable iff (rst)
    $past(dat_hs) |-> (cnt_q == '0));

endmodule

// File: rtl/lhs_clk_lane.sv
module lhs_clk_lane
  import lhs_pkg::*;
#(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic [FW-1:0] lpx,
  input  logic [FW-1:0] prep,
  input  logic [FW-1:0] zero,
  input  logic [FW-1:0] trail,
  input  logic [FW-1:0] exit_t,
  output logic [1:0]    lp_o,
  output logic          hs_o,
  output logic          run_o
);

  clk_st_e       st_q, st_d;
  logic [FW-1:0] cnt_q, cnt_d;
  logic          done;
  logic [1:0]    lp_d;
  logic          hs_d;

  function automatic logic [FW-1:0] ld(input logic [FW-1:0] f);
    return (f == '0) ? '0 : f - 1'b1;
  endfunction

  assign done = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = done ? '0 : cnt_q - 1'b1;
    unique case (st_q)
      CL_STOP:  if (start) begin st_d = CL_REQ;   cnt_d = ld(lpx);    end
      CL_REQ:   if (done)  begin st_d = CL_PREP;  cnt_d = ld(prep);   end
      CL_PREP:  if (done)  begin st_d = CL_ZERO;  cnt_d = ld(zero);   end
      CL_ZERO:  if (done)  begin st_d = CL_RUN;                       end
      CL_RUN:   if (stop)  begin st_d = CL_TRAIL; cnt_d = ld(trail);  end
      CL_TRAIL: if (done)  begin st_d = CL_EXIT;  cnt_d = ld(exit_t); end
      CL_EXIT:  if (done)  begin st_d = CL_STOP;                      end
      default:  st_d = CL_STOP;
    endcase
  end

  always_comb begin
    lp_d = LP_BRDG;
    hs_d = 1'b0;
    unique case (st_d)
      CL_STOP, CL_EXIT:          lp_d = LP_STOP;
      CL_REQ:                    lp_d = LP_HSRQ;
      CL_PREP:                   lp_d = LP_BRDG;
      CL_ZERO, CL_RUN, CL_TRAIL: hs_d = 1'b1;
      default:                   lp_d = LP_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= CL_STOP;
      cnt_q <= '0;
      lp_o  <= LP_STOP;
      hs_o  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      lp_o  <= lp_d;
      hs_o  <= hs_d;
    end
  end

  assign run_o = (st_q == CL_RUN);

  a_r2_run_after_zero: assert property (@(posedge clk) disable iff (rst)
    (st_q == CL_RUN && $past(st_q) != CL_RUN) |-> ($past(st_q) == CL_ZERO));

  a_r2_hs_not_lp: assert property (@(posedge clk) disable iff (rst)
    hs_o |-> (lp_o == LP_BRDG));

endmodule

// File: rtl/lhs_dat_lane.sv
module lhs_dat_lane
  import lhs_pkg::*;
#(
  parameter int             FW   = 8,
  parameter int             BW   = 8,
  parameter logic [BW-1:0]  SYNC = 8'hB8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          clk_run,
  input  logic [FW-1:0] lpx,
  input  logic [FW-1:0] prep,
  input  logic [FW-1:0] zero,
  input  logic [FW-1:0] trail,
  input  logic [FW-1:0] exit_t,
  input  logic [BW-1:0] tx_data,
  input  logic          tx_valid,
  input  logic          tx_last,
  output logic [1:0]    lp_o,
  output logic          hs_o,
  output logic [BW-1:0] byte_o,
  output logic          rdy_o,
  output logic          idle_o
);

  dat_st_e       st_q, st_d;
  logic [FW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] byte_d;
  logic          done;
  logic [1:0]    lp_d;
  logic          hs_d;
  logic          rdy_d;

  function automatic logic [FW-1:0] ld(input logic [FW-1:0] f);
    return (f == '0) ? '0 : f - 1'b1;
  endfunction

  assign done = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = done ? '0 : cnt_q - 1'b1;
    byte_d = byte_o;
    unique case (st_q)
      DL_IDLE:
        if (req && clk_run) begin st_d = DL_REQ; cnt_d = ld(lpx); end
      DL_REQ:
        if (done) begin st_d = DL_PREP; cnt_d = ld(prep); end
      DL_PREP:
        if (done) begin st_d = DL_ZERO; cnt_d = ld(zero); byte_d = '0; end
      DL_ZERO:
        if (done) begin st_d = DL_SYNC; byte_d = SYNC; end
      DL_SYNC, DL_PAY: begin
        st_d = DL_PAY;
        if (tx_valid) begin
          byte_d = tx_data;
          if (tx_last) st_d = DL_LAST;
        end
      end
      DL_LAST: begin
        st_d   = DL_TRAIL;
        cnt_d  = ld(trail);
        byte_d = {BW{~byte_o[BW-1]}};
      end
      DL_TRAIL:
        if (done) begin st_d = DL_EXIT; cnt_d = ld(exit_t); byte_d = '0; end
      DL_EXIT:
        if (done) st_d = DL_IDLE;
      default: st_d = DL_IDLE;
    endcase
  end

  always_comb begin
    lp_d  = LP_BRDG;
    hs_d  = 1'b0;
    rdy_d = 1'b0;
    unique case (st_d)
      DL_IDLE, DL_EXIT: lp_d = LP_STOP;
      DL_REQ:           lp_d = LP_HSRQ;
      DL_PREP:          lp_d = LP_BRDG;
      DL_SYNC, DL_PAY: begin hs_d = 1'b1; rdy_d = 1'b1; end
      DL_ZERO, DL_LAST, DL_TRAIL: hs_d = 1'b1;
      default:          lp_d = LP_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= DL_IDLE;
      cnt_q  <= '0;
      byte_o <= '0;
      lp_o   <= LP_STOP;
      hs_o   <= 1'b0;
      rdy_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      byte_o <= byte_d;
      lp_o   <= lp_d;
      hs_o   <= hs_d;
      rdy_o  <= rdy_d;
    end
  end

  assign idle_o = (st_q == DL_IDLE);

  a_r3_leave_stop_needs_clock: assert property (@(posedge clk) disable iff (rst)
    (lp_o == LP_HSRQ && $past(lp_o) == LP_STOP) |-> $past(clk_run));

  a_r4_sync_follows_zero: assert property (@(posedge clk) disable iff (rst)
    (st_q == DL_SYNC) |-> ($past(st_q) == DL_ZERO && byte_o == SYNC));

  a_r5_ready_in_hs: assert property (@(posedge clk) disable iff (rst)
    rdy_o |-> hs_o);

  a_r6_trail_steady: assert property (@(posedge clk) disable iff (rst)
    (st_q == DL_TRAIL && $past(st_q) == DL_TRAIL) |-> $stable(byte_o));

endmodule

// File: rtl/lane_hs_seq.sv
module lane_hs_seq #(
  parameter logic [7:0] SYNC_BYTE = 8'hB8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] t_word0,
  input  logic [31:0] t_word1,
  input  logic [31:0] t_word2,
  input  logic [31:0] t_word3,
  input  logic        clk_hs_en,
  input  logic        clk_noncont,
  input  logic        burst_req,
  input  logic [7:0]  tx_data,
  input  logic        tx_valid,
  input  logic        tx_last,
  output logic [1:0]  clk_lp,
  output logic        clk_hs_oe,
  output logic [1:0]  dat_lp,
  output logic        dat_hs_oe,
  output logic [7:0]  dat_byte,
  output logic        tx_ready
);

  localparam int FW  = 8;
  localparam int NW  = 4;
  localparam int BW  = 8;

  // field unpacking; positions fixed by the timing word layout
  logic [FW-1:0] f_lpx, f_dprep, f_dzero, f_dtrail, f_dexit;
  logic [FW-1:0] f_cprep, f_cpost, f_ctrail, f_czero, f_cexit;
  logic          tim_unused;

  assign f_lpx    = t_word0[7:0];
  assign f_dprep  = t_word0[15:8];
  assign f_dzero  = t_word0[23:16];
  assign f_dtrail = t_word0[31:24];
  assign f_dexit  = t_word1[31:24];
  assign f_czero  = {{(FW-NW){1'b0}}, t_word2[19:16]};
  assign f_ctrail = t_word2[31:24];
  assign f_cprep  = t_word3[7:0];
  assign f_cpost  = t_word3[15:8];
  assign f_cexit  = {{(FW-NW){1'b0}}, t_word3[19:16]};
  // turnaround fields are held by software only
  assign tim_unused = ^{t_word1[23:0], t_word2[15:0], t_word2[23:20], t_word3[31:20]};

  logic c_run, c_start, c_stop;
  logic d_idle, post_ok;

  assign c_start = clk_hs_en && (!clk_noncont || burst_req);
  assign c_stop  = (!clk_hs_en || clk_noncont) && d_idle && !burst_req && post_ok;

  lhs_clk_lane #(.FW(FW)) u_clk (
    .clk    (clk),
    .rst    (rst),
    .start  (c_start),
    .stop   (c_stop),
    .lpx    (f_lpx),
    .prep   (f_cprep),
    .zero   (f_czero),
    .trail  (f_ctrail),
    .exit_t (f_cexit),
    .lp_o   (clk_lp),
    .hs_o   (clk_hs_oe),
    .run_o  (c_run)
  );

  lhs_dat_lane #(.FW(FW), .BW(BW), .SYNC(SYNC_BYTE)) u_dat (
    .clk      (clk),
    .rst      (rst),
    .req      (burst_req),
    .clk_run  (c_run),
    .lpx      (f_lpx),
    .prep     (f_dprep),
    .zero     (f_dzero),
    .trail    (f_dtrail),
    .exit_t   (f_dexit),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_last  (tx_last),
    .lp_o     (dat_lp),
    .hs_o     (dat_hs_oe),
    .byte_o   (dat_byte),
    .rdy_o    (tx_ready),
    .idle_o   (d_idle)
  );

  lhs_post_guard #(.FW(FW)) u_post (
    .clk      (clk),
    .rst      (rst),
    .dat_hs   (dat_hs_oe),
    .post_len (f_cpost),
    .ok_o     (post_ok)
  );

  a_r12_clock_covers_data: assert property (@(posedge clk) disable iff (rst)
    dat_hs_oe |-> clk_hs_oe);

  a_r9_stop_after_post: assert property (@(posedge clk) disable iff (rst)
    $fell(c_run) |-> ($past(post_ok) && $past(d_idle)));

endmodule

// File: tb/lane_hs_seq_tb.sv
module lane_hs_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] t_word0 = '0, t_word1 = '0, t_word2 = '0, t_word3 = '0;
  logic        clk_hs_en = 1'b0, clk_noncont = 1'b1, burst_req = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0, tx_last = 1'b0;
  logic [1:0]  clk_lp, dat_lp;
  logic        clk_hs_oe, dat_hs_oe, tx_ready;
  logic [7:0]  dat_byte;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  int g_lpx, g_dprep, g_dzero, g_dtrail, g_dexit;
  int g_cprep, g_czero, g_ctrail, g_cpost, g_cexit;

  logic [7:0] strm [0:63];
  logic [7:0] pay  [0:15];

  always #5 clk = ~clk;

  lane_hs_seq u_dut (
    .clk(clk), .rst(rst), .t_word0(t_word0), .t_word1(t_word1),
    .t_word2(t_word2), .t_word3(t_word3), .clk_hs_en(clk_hs_en),
    .clk_noncont(clk_noncont), .burst_req(burst_req), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .clk_lp(clk_lp),
    .clk_hs_oe(clk_hs_oe), .dat_lp(dat_lp), .dat_hs_oe(dat_hs_oe),
    .dat_byte(dat_byte), .tx_ready(tx_ready)
  );

  function automatic int plen(input int f);
    return (f == 0) ? 1 : f;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      summary();
    end
  end

  task automatic set_timing(input int lpx, dprep, dzero, dtrail, dexit,
                            input int cprep, czero, ctrail, cpost, cexit);
    g_lpx = lpx; g_dprep = dprep; g_dzero = dzero; g_dtrail = dtrail; g_dexit = dexit;
    g_cprep = cprep; g_czero = czero; g_ctrail = ctrail; g_cpost = cpost; g_cexit = cexit;
    t_word0 = {8'(dtrail), 8'(dzero), 8'(dprep), 8'(lpx)};
    t_word1 = {8'(dexit), 24'hA5C3E1};  // turnaround bits: no effect
    t_word2 = {8'(ctrail), 4'h0, 4'(czero), 16'h0};
    t_word3 = {12'h0, 4'(cexit), 8'(cpost), 8'(cprep)};
  endtask

  // R1: state after reset
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 clk_lp", int'(clk_lp), 3);
    chk("R1 dat_lp", int'(dat_lp), 3);
    chk("R1 hs enables", int'({clk_hs_oe, dat_hs_oe}), 0);
    chk("R1 tx_ready", int'(tx_ready), 0);
    chk("R1 dat_byte", int'(dat_byte), 0);
    rst = 1'b0;
  endtask

  // R3: request ignored while the clock lane is disabled
  task automatic t_gate();
    int moved = 0;
    clk_hs_en = 1'b0; clk_noncont = 1'b1; burst_req = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dat_lp != 2'b11 || clk_lp != 2'b11 || dat_hs_oe || clk_hs_oe) moved++;
    end
    chk("R3 lanes left stop without clock enable", moved, 0);
    burst_req = 1'b0;
    @(negedge clk);
  endtask

  // one burst; cont=1 means the clock lane is already running continuously
  task automatic run_burst(input string tg, input bit cont, input int n,
                           input logic [7:0] last_b);
    int idx = 0, c01 = 0, c00 = 0, chs = 0, d01 = 0, d00 = 0, ns = 0;
    int drop = 0, post_hs = 0, rdy = 0, bz = 0, bp = 0, bf = 0;
    int zl, tl, xl, pl, exp_ns, exp_post;
    bit started = 0, hs_seen = 0, fin = 0;
    logic [7:0] fill;
    for (int i = 0; i < n; i++) pay[i] = (i == n - 1) ? last_b : 8'(8'h15 * (i + 3));
    burst_req = 1'b1;
    for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
      @(negedge clk);
      if (!started && dat_lp == 2'b01 && !dat_hs_oe) begin
        started = 1; burst_req = 1'b0;
      end
      if (!started) begin
        if (clk_lp == 2'b01) c01++;
        if (clk_lp == 2'b00 && !clk_hs_oe) c00++;
        if (clk_hs_oe) chs++;
      end
      if (started && !dat_hs_oe && dat_lp == 2'b01) d01++;
      if (started && !dat_hs_oe && dat_lp == 2'b00) d00++;
      if (dat_hs_oe) begin
        if (ns < 64) strm[ns] = dat_byte;
        ns++; hs_seen = 1;
      end else if (hs_seen) begin
        drop++;
        if (clk_hs_oe) post_hs++;
      end
      if (tx_ready) rdy++;
      if (tx_ready && idx < n) begin
        tx_valid = 1'b1; tx_data = pay[idx]; tx_last = (idx == n - 1); idx++;
      end else begin
        tx_valid = 1'b0; tx_last = 1'b0;
      end
      if (drop >= 40) fin = 1;
    end
    chk({tg, " R5 burst completed"}, int'(fin), 1);
    zl = plen(g_dzero); tl = plen(g_dtrail); xl = plen(g_dexit); pl = plen(g_cpost);
    if (!cont) begin
      chk({tg, " R2 clock LP-01 cycles"}, c01, plen(g_lpx));
      chk({tg, " R2 clock LP-00 cycles"}, c00, plen(g_cprep));
      chk({tg, " R2 clock hs before data LP-01"}, chs, plen(g_czero) + 1);
      exp_post = ((xl > pl) ? xl : pl) + 1 + plen(g_ctrail);
      chk({tg, " R9 clock hs after data drop"}, post_hs, exp_post);
      chk({tg, " R9 clock back to stop"}, int'(clk_lp), 3);
    end else begin
      chk({tg, " R10 clock still running after burst"}, int'(clk_hs_oe), 1);
    end
    chk({tg, " R4 data LP-01 cycles"}, d01, plen(g_lpx));
    chk({tg, " R4 data LP-00 cycles"}, d00, plen(g_dprep));
    exp_ns = zl + 1 + n + tl;
    chk({tg, " R6 hs byte count"}, ns, exp_ns);
    if (ns == exp_ns) begin
      for (int i = 0; i < zl; i++) if (strm[i] != 8'h00) bz++;
      chk({tg, " R4 zero bytes wrong"}, bz, 0);
      chk({tg, " R4 sync byte"}, int'(strm[zl]), 8'hB8);
      for (int i = 0; i < n; i++) if (strm[zl + 1 + i] != pay[i]) bp++;
      chk({tg, " R5 payload bytes wrong"}, bp, 0);
      fill = last_b[7] ? 8'h00 : 8'hFF;
      for (int i = 0; i < tl; i++) if (strm[zl + 1 + n + i] != fill) bf++;
      chk({tg, " R6 trail bytes wrong"}, bf, 0);
    end
    chk({tg, " R5 ready cycles"}, rdy, n);
    chk({tg, " R5 ready low after last"}, int'(tx_ready), 0);
  endtask

  // R10, R11: continuous clock start, hold and release
  task automatic t_continuous();
    int w = 0, trail_n = 0, stop_n = 0;
    bit seen = 0;
    set_timing(2, 1, 3, 2, 3, 1, 2, 4, 0, 3);
    clk_noncont = 1'b0; clk_hs_en = 1'b1;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      if (clk_hs_oe) seen = 1;
      w++;
    end
    chk("R10 clock started without request", int'(seen), 1);
    repeat (5) @(negedge clk);
    run_burst("cont", 1'b1, 3, 8'hA5);
    clk_hs_en = 1'b0;
    seen = 0;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      if (clk_hs_oe) trail_n++;
      else seen = 1;
    end
    chk("R10 clock trail cycles", trail_n, plen(g_ctrail));
    chk("R10 clock stop code", int'(clk_lp), 3);
    clk_hs_en = 1'b1;
    stop_n = 1;
    seen = 0;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      if (clk_lp == 2'b01) seen = 1;
      else if (clk_lp == 2'b11) stop_n++;
    end
    chk("R11 clock stop cycles before restart", stop_n, plen(g_cexit) + 1);
    repeat (20) @(negedge clk);
  endtask

  // R7: stop gap between back-to-back bursts with request held
  task automatic t_exit_gap();
    int gaps = 0, gap = 0, bad_gap = 0;
    bit counting = 0, prev_hs = 0;
    burst_req = 1'b1;
    for (int i = 0; i < 1000 && gaps < 2; i++) begin
      @(negedge clk);
      if (prev_hs && !dat_hs_oe) begin counting = 1; gap = 0; end
      if (counting && !dat_hs_oe && dat_lp == 2'b11) gap++;
      if (counting && dat_lp == 2'b01) begin
        counting = 0; gaps++;
        if (gap != plen(g_dexit) + 1) begin
          bad_gap++;
          $display("FAIL R7 gap actual=%0d expected=%0d", gap, plen(g_dexit) + 1);
        end
      end
      prev_hs = dat_hs_oe;
      tx_valid = tx_ready; tx_data = 8'h5A; tx_last = 1'b1;
    end
    n_chk++;
    if (bad_gap != 0) n_bad++;
    chk("R7 gaps observed", gaps, 2);
    burst_req = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      tx_valid = tx_ready; tx_data = 8'h5A; tx_last = 1'b1;
    end
    tx_valid = 1'b0; tx_last = 1'b0;
    chk("R7 data back to stop", int'(dat_lp), 3);
  endtask

  initial begin
    t_reset();
    t_gate();
    set_timing(3, 4, 5, 6, 4, 2, 3, 5, 9, 2);
    clk_noncont = 1'b1; clk_hs_en = 1'b1;
    @(negedge clk);
    run_burst("noncont", 1'b0, 4, 8'h3C);
    // R8: all fields zero, each phase one cycle
    set_timing(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_burst("R8 zero fields", 1'b0, 1, 8'h80);
    t_continuous();
    t_exit_gap();
    summary();
  end

endmodule